// File: doc/BRIEF.md
# Framed Serial Register Loader

This block accepts 16-bit command words on a single serial data line and turns them into register writes in the master clock domain. A word is framed by an active-low frame input. Bits are taken on the falling edges of a slow serial clock, most significant bit first. Several words may follow one another inside a single frame.

Each completed word is split into two bytes. The upper byte carries a 4-bit opcode and a 4-bit destination address. The lower byte carries data. A staging opcode parks one byte in a defer register. A commit opcode then issues a single 16-bit write that combines the parked byte with its own byte. Software can therefore build a wide destination register in 16-bit halves, and each half changes in one step. A control opcode updates a small set of control outputs in one step.

A finished word crosses into the master clock domain through a toggle flag and a synchronizer. A held copy of the word is read only once the toggle has settled.

Top module: `ser_reg_loader`

## Requirements
- R1: While reset is asserted and after it is released, `wr_en`, `wr_addr`, `wr_data` and all control outputs are 0.
- R2: While `frame_n` is low, one bit of `ser_din` is taken on each falling edge of `ser_clk`, most significant bit first. Every 16 bits form one word. Word bits [15:12] are the opcode, bits [11:8] the address and bits [7:0] the data byte.
- R3: If `frame_n` goes high before the 16th bit of a word, the partial word is discarded. It causes no write and no control change, and the next frame starts a fresh word.
- R4: Words sent back to back inside one frame are each decoded, in order.
- R5: Opcode 0x1 stores the data byte in the defer register and produces no write strobe.
- R6: Opcode 0x2 produces a write with `wr_addr` = word bits [11:8] and `wr_data` = {defer byte, word bits [7:0]}.
- R7: Each commit word raises `wr_en` for exactly one master clock cycle. `wr_addr` and `wr_data` keep their values until the next commit.
- R8: Opcode 0x3 loads all control outputs at once from the data byte: bit 7 to `ctrl_pwrdn`, bit 6 to `ctrl_srcsel`, bits [2:1] to `ctrl_psel` and bit 0 to `ctrl_fsel`.
- R9: Every other opcode is ignored. It causes no write, leaves the control outputs unchanged and leaves the defer byte unchanged.
- R10: The effect of a word is visible at the outputs no later than 5 master clock cycles after the falling `ser_clk` edge that carries its last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data taken on falling edge |
| frame_n | input | 1 | Active-low word framing |
| ser_din | input | 1 | Serial data, MSB first |
| wr_en | output | 1 | One-cycle write strobe |
| wr_addr | output | 4 | Write destination address |
| wr_data | output | 16 | Write data {defer byte, new byte} |
| ctrl_pwrdn | output | 1 | Power-down control |
| ctrl_srcsel | output | 1 | Select-source control |
| ctrl_fsel | output | 1 | Frequency select bit |
| ctrl_psel | output | 2 | Phase select bits |

## Verification
Four properties are checked on every master clock cycle:
- a strobe always follows a synchronized commit word and lasts one cycle;
- the write outputs hold steady between strobes;
- the control outputs change only after a control word;
- an unknown opcode changes nothing.

Other behaviours can only be shown by the bench's scenarios. These are the serial framing itself (bit order, discarding a partial word, several words in one frame) and the byte carried through the defer register. They also include the bound on latency after the last serial edge.

// File: rtl/ser_loader_pkg.sv
package ser_loader_pkg;
  localparam logic [3:0] OP_STAGE  = 4'h1;
  localparam logic [3:0] OP_COMMIT = 4'h2;
  localparam logic [3:0] OP_CTRL   = 4'h3;

  localparam int CTRL_PWRDN_BIT = 7;
  localparam int CTRL_SRC_BIT   = 6;
  localparam int CTRL_PSEL_LSB  = 1;
  localparam int CTRL_FSEL_BIT  = 0;

  typedef struct packed {
    logic       pwrdn;
    logic       srcsel;
    logic [1:0] psel;
    logic       fsel;
  } ctrl_t;
endpackage

// File: rtl/sdes_shift.sv
module sdes_shift #(
  parameter int WORD_W = 16
) (
  input  logic              ser_clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              ser_din,
  output logic [WORD_W-1:0] word_q,
  output logic              word_tgl
);
  localparam int CNT_W = $clog2(WORD_W);

  // frame high acts as an asynchronous clear of the partial word
  logic             clr_n;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [WORD_W-2:0] sh_q, sh_d;
  logic             last_bit;

  assign clr_n = rst_n & ~frame_n;

  always_comb begin
    last_bit = (cnt_q == CNT_W'(WORD_W-1));
    cnt_d    = last_bit ? '0 : cnt_q + 1'b1;
    sh_d     = {sh_q[WORD_W-3:0], ser_din};
  end

  always_ff @(negedge ser_clk or negedge clr_n) begin
    if (!clr_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  // completed word held stable until the next word completes
  always_ff @(negedge ser_clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      word_tgl <= 1'b0;
    end else if (!frame_n && last_bit) begin
      word_q   <= {sh_q, ser_din};
      word_tgl <= ~word_tgl;
    end
  end
endmodule

// File: rtl/sdes_tog_sync.sv
module sdes_tog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              seen_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], tgl_in};
    pulse  = sync_q[STAGES-1] ^ seen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      seen_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      seen_q <= sync_q[STAGES-1];
    end
  end
endmodule

// File: rtl/sdes_decode.sv
module sdes_decode
  import ser_loader_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int OP_W   = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_pulse,
  input  logic [WORD_W-1:0] word_in,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output ctrl_t             ctrl
);
  localparam int BYTE_W = WORD_W - OP_W - ADDR_W;

  logic [OP_W-1:0]   op;
  logic [ADDR_W-1:0] addr;
  logic [BYTE_W-1:0] dbyte;
  logic [BYTE_W-1:0] defer_q, defer_d;
  logic              wr_en_d;
  logic [ADDR_W-1:0] addr_d;
  logic [WORD_W-1:0] data_d;
  ctrl_t             ctrl_d;

  always_comb begin
    op      = word_in[WORD_W-1 -: OP_W];
    addr    = word_in[BYTE_W +: ADDR_W];
    dbyte   = word_in[BYTE_W-1:0];
    defer_d = defer_q;
    wr_en_d = 1'b0;
    addr_d  = wr_addr;
    data_d  = wr_data;
    ctrl_d  = ctrl;
    if (word_pulse) begin
      case (op)
        OP_STAGE:  defer_d = dbyte;
        OP_COMMIT: begin
          wr_en_d = 1'b1;
          addr_d  = addr;
          data_d  = {defer_q, dbyte};
        end
        OP_CTRL: begin
          ctrl_d.pwrdn  = dbyte[CTRL_PWRDN_BIT];
          ctrl_d.srcsel = dbyte[CTRL_SRC_BIT];
          ctrl_d.psel   = dbyte[CTRL_PSEL_LSB +: 2];
          ctrl_d.fsel   = dbyte[CTRL_FSEL_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      defer_q <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      ctrl    <= '0;
    end else begin
      defer_q <= defer_d;
      wr_en   <= wr_en_d;
      wr_addr <= addr_d;
      wr_data <= data_d;
      ctrl    <= ctrl_d;
    end
  end
endmodule

// File: rtl/ser_reg_loader.sv
module ser_reg_loader
  import ser_loader_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int OP_W        = 4,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              frame_n,
  input  logic              ser_din,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              ctrl_pwrdn,
  output logic              ctrl_srcsel,
  output logic              ctrl_fsel,
  output logic [1:0]        ctrl_psel
);
  logic [1:0]        rst_sq;
  logic              rst_mn;
  logic [WORD_W-1:0] word_ser;
  logic              word_tgl;
  logic              word_pulse;
  ctrl_t             ctrl;

  // reset asserted asynchronously, released on the master clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= '0;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_mn = rst_sq[1];

  sdes_shift #(.WORD_W(WORD_W)) u_shift (
    .ser_clk  (ser_clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .ser_din  (ser_din),
    .word_q   (word_ser),
    .word_tgl (word_tgl)
  );

  sdes_tog_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_mn),
    .tgl_in (word_tgl),
    .pulse  (word_pulse)
  );

  sdes_decode #(.WORD_W(WORD_W), .OP_W(OP_W), .ADDR_W(ADDR_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_mn),
    .word_pulse (word_pulse),
    .word_in    (word_ser),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ctrl       (ctrl)
  );

  assign ctrl_pwrdn  = ctrl.pwrdn;
  assign ctrl_srcsel = ctrl.srcsel;
  assign ctrl_fsel   = ctrl.fsel;
  assign ctrl_psel   = ctrl.psel;
endmodule

// File: rtl/ser_reg_loader_chk.sv
module ser_reg_loader_chk
  import ser_loader_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_mn,
  input logic              word_pulse,
  input logic [3:0]        word_op,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic [4:0]        ctrl_bits
);
  logic op_known;
  assign op_known = (word_op == OP_STAGE) || (word_op == OP_COMMIT) ||
                    (word_op == OP_CTRL);

  assert_strobe_from_commit_R6: assert property (@(posedge clk) disable iff (!rst_mn)
    wr_en |-> ($past(word_pulse) && $past(word_op) == OP_COMMIT));

  assert_strobe_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_mn)
    wr_en |=> !wr_en);

  assert_write_held_R7: assert property (@(posedge clk) disable iff (!rst_mn)
    !wr_en |-> ($stable(wr_data) && $stable(wr_addr)));

  assert_ctrl_from_word_R8: assert property (@(posedge clk) disable iff (!rst_mn)
    !$stable(ctrl_bits) |-> ($past(word_pulse) && $past(word_op) == OP_CTRL));

  assert_unknown_op_inert_R9: assert property (@(posedge clk) disable iff (!rst_mn)
    (word_pulse && !op_known) |=> (!wr_en && $stable(ctrl_bits)));
endmodule

bind ser_reg_loader ser_reg_loader_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_mn     (rst_mn),
  .word_pulse (word_pulse),
  .word_op    (word_ser[WORD_W-1 -: 4]),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .ctrl_bits  ({ctrl_pwrdn, ctrl_srcsel, ctrl_psel, ctrl_fsel})
);

// File: tb/ser_reg_loader_tb.sv
`timescale 1ns/1ps
module ser_reg_loader_tb;
  localparam int HALF_SCLK = 20;

  logic        clk;
  logic        rst_n;
  logic        ser_clk;
  logic        frame_n;
  logic        ser_din;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic        ctrl_pwrdn, ctrl_srcsel, ctrl_fsel;
  logic [1:0]  ctrl_psel;

  int checks;
  int failures;
  bit done;
  bit prev_wr;
  logic [19:0] exp_q[$];
  logic [19:0] last_write;

  ser_reg_loader u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .frame_n(frame_n),
    .ser_din(ser_din), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_pwrdn(ctrl_pwrdn), .ctrl_srcsel(ctrl_srcsel),
    .ctrl_fsel(ctrl_fsel), .ctrl_psel(ctrl_psel)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: compares every strobe against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wr_en && prev_wr)
        check(1'b0, "R7", "strobe longer than one cycle", 32'd2, 32'd1);
      if (wr_en) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected write strobe", {12'd0, wr_addr, wr_data}, 32'd0);
        end else begin
          logic [19:0] e;
          e = exp_q.pop_front();
          check({wr_addr, wr_data} == e, "R6", "write addr/data",
                {12'd0, wr_addr, wr_data}, {12'd0, e});
        end
      end
      prev_wr <= wr_en;
    end
  end

  task automatic shift_bits(input logic [15:0] w, input int nbits);
    for (int i = 15; i > 15 - nbits; i--) begin
      ser_din = w[i];
      #(HALF_SCLK);
      ser_clk = 1'b0;
      #(HALF_SCLK);
      ser_clk = 1'b1;
    end
  endtask

  task automatic gap();
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic send_word(input logic [15:0] w, input int nbits);
    frame_n = 1'b0;
    #(HALF_SCLK);
    shift_bits(w, nbits);
    #(HALF_SCLK);
    frame_n = 1'b1;
  endtask

  task automatic stage(input logic [7:0] b);
    send_word({4'h1, 4'h0, b}, 16);
    gap();
  endtask

  task automatic commit(input logic [3:0] a, input logic [7:0] b, input logic [7:0] dfr);
    exp_q.push_back({a, dfr, b});
    last_write = {a, dfr, b};
    send_word({4'h2, a, b}, 16);
    gap();
  endtask

  task automatic check_ctrl(input logic [4:0] exp, input string req);
    check({ctrl_pwrdn, ctrl_srcsel, ctrl_psel, ctrl_fsel} == exp, req, "control outputs",
          {27'd0, ctrl_pwrdn, ctrl_srcsel, ctrl_psel, ctrl_fsel}, {27'd0, exp});
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0; prev_wr = 1'b0;
    last_write = '0;
    rst_n = 1'b0; ser_clk = 1'b1; frame_n = 1'b1; ser_din = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(wr_en == 1'b0, "R1", "wr_en in reset", {31'd0, wr_en}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check(wr_en == 1'b0, "R1", "wr_en after reset", {31'd0, wr_en}, 32'd0);
    check({wr_addr, wr_data} == 20'd0, "R1", "write outputs after reset",
          {12'd0, wr_addr, wr_data}, 32'd0);
    check_ctrl(5'b0, "R1");

    // R2 R5 R6: stage then commit, MSB-first words
    stage(8'hA5);
    check(exp_q.size() == 0, "R5", "stage produced no strobe", exp_q.size(), 0);
    commit(4'h3, 8'h3C, 8'hA5);
    check(exp_q.size() == 0, "R6", "commit strobe seen", exp_q.size(), 0);

    // R8 R10: control word, checked 4 master cycles after the last serial edge
    frame_n = 1'b0;
    #(HALF_SCLK);
    shift_bits(16'h30C5, 16);
    repeat (4) @(posedge clk);
    #1;
    frame_n = 1'b1;
    check_ctrl(5'b11_10_1, "R10");
    gap();
    check_ctrl(5'b11_10_1, "R8");
    send_word(16'h3000, 16);
    gap();
    check_ctrl(5'b0, "R8");
    send_word(16'h3042, 16);
    gap();
    check_ctrl(5'b01_01_0, "R8");

    // R3: partial word dropped, next frame starts fresh
    send_word(16'h2F77, 9);
    gap();
    check(wr_data == last_write[15:0], "R3", "partial word left data", wr_data, last_write[15:0]);
    check_ctrl(5'b01_01_0, "R3");
    commit(4'h5, 8'h11, 8'hA5);
    check(exp_q.size() == 0, "R3", "fresh word after discard", exp_q.size(), 0);

    // R9: unknown opcodes touch nothing, defer kept
    send_word(16'h7FFF, 16);
    gap();
    send_word(16'h00FF, 16);
    gap();
    send_word(16'hF3FF, 16);
    gap();
    check_ctrl(5'b01_01_0, "R9");
    check(wr_data == last_write[15:0], "R9", "data after ignored ops", wr_data, last_write[15:0]);
    commit(4'h6, 8'h22, 8'hA5);

    // R4: three words in one frame
    exp_q.push_back({4'hF, 8'h12, 8'h34});
    last_write = {4'hF, 8'h12, 8'h34};
    frame_n = 1'b0;
    #(HALF_SCLK);
    shift_bits(16'h1012, 16);
    shift_bits(16'h2F34, 16);
    shift_bits(16'h3081, 16);
    #(HALF_SCLK);
    frame_n = 1'b1;
    gap();
    check(exp_q.size() == 0, "R4", "commit within frame", exp_q.size(), 0);
    check_ctrl(5'b10_00_1, "R4");

    // R7: write outputs held after the last strobe
    repeat (10) @(posedge clk);
    #1;
    check({wr_addr, wr_data} == last_write, "R7", "write outputs held",
          {12'd0, wr_addr, wr_data}, {12'd0, last_write});
    check(wr_en == 1'b0, "R7", "strobe low when idle", {31'd0, wr_en}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule